// File: doc/BRIEF.md
# Diskette Controller Host Register Sequencer

This block is the programmed-I/O front end of a single-density diskette controller. A host sees two word-addressed registers: a control/status word and an 8-bit data register. Every byte the controller moves goes through the data register. This covers sector contents, sector and track numbers, status and error codes. A transfer-request flag paces the traffic one byte at a time. The block holds a sector buffer of `NBYTES` bytes. It can fill that buffer from the host or empty it to the host.

Sector reads and writes collect a sector byte and then a track byte. They then hand the command to a separate disk access engine through a start/complete handshake. That engine also sees the buffer through its own port. When any command ends, the block goes idle and sets done. It raises an interrupt request if interrupts are enabled, and it overwrites the data register with the final status. Writing the init bit clears every register and starts a power-up command in the engine.

Top module: `dskc_seq`

## Requirements
- R1: After reset the control/status readback is 0x0000, `irq` is low and `eng_start` is low.
- R2: Address bit 1 selects the register: 0 is control/status and 1 is data. A control/status read returns only error (bit 15), transfer request (bit 7), interrupt enable (bit 6) and done (bit 5), with all other bits zero. A data read returns the 8-bit data register in bits 7:0.
- R3: Fill (function 0, control word bits 3:1, GO in bit 0) sets transfer request at once. Each accepted data write clears the request and stores the byte in the buffer at the next position. The request returns exactly `XFER_DLY` cycles after the write. After `NBYTES` bytes the command completes.
- R4: Empty (function 1) places buffer byte 0 in the data register and then sets transfer request. A data read while the request is set clears it and, `XFER_DLY` cycles later, presents the next byte. After `NBYTES` bytes have been read the command completes.
- R5: While a command is active, a data write with transfer request clear is ignored. A byte write to the odd (high) byte of the data register is always ignored. While idle, a data write stores bits 7:0.
- R6: GO is accepted only while idle. While busy, a write with GO set changes only interrupt enable, and the active command continues.
- R7: A control/status write without GO or init updates only interrupt enable (bit 6). Clearing it drops `irq`. Setting it while done is set raises `irq`.
- R8: On completion the block returns to idle, sets done, clears transfer request and raises `irq` if interrupt enable is set. It sets error if the new error code is nonzero. It then loads the status byte into the data register: the engine's status after a sector command, the held status otherwise.
- R9: Read (3), write (2) and deleted-data write (6) take a sector byte (low `SECT_W` bits kept) and then a track byte. The block then gives a one-cycle `eng_start` with function, drive (control bit 4), sector and track, and completes on `eng_done`.
- R10: Function 7 loads the held error code into the data register without setting error. Function 5 loads the held status byte.
- R11: A control/status write with bit 14 set clears all registers and done. It then gives `eng_start` with `eng_pwrup` high, and completes on `eng_done` with the engine's status.
- R12: A byte write to control/status is merged into the low half (address bit 0 = 0) or the high half (address bit 0 = 1), with the byte on `bus_wdata[7:0]`, before decoding.
- R13: The engine buffer port reads the byte stored at `eng_buf_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 1 selects register, bit 0 selects byte lane |
| bus_byte | input | 1 | Byte access (data on bits 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle command start to the engine |
| eng_pwrup | output | 1 | Start is the power-up command |
| eng_func | output | 3 | Function code of the command |
| eng_drive | output | 1 | Selected drive |
| eng_sector | output | SECT_W | Sector number |
| eng_track | output | TRK_W | Track number |
| eng_done | input | 1 | Engine completion pulse |
| eng_ecode | input | 8 | Engine error code, valid with eng_done |
| eng_status | input | 8 | Engine status byte, valid with eng_done |
| eng_buf_addr | input | AW | Engine buffer address |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data |

## Verification
The checker watches several rules on every cycle. Transfer request is never set while idle. The buffer pointer never passes `NBYTES`. Interrupt request follows interrupt enable and done. `eng_start` never lasts two cycles. GO while busy leaves the function unchanged. An odd-lane data write while idle leaves the data register unchanged. Other behaviour can only be shown by the bench scenarios. These include the byte order through fill and empty, the exact request delay, and the sector-then-track sequence reaching the engine. They also include which byte lands in the data register at completion for each function, and the lane merge that turns a high-byte write into init.

// File: rtl/dskc_pkg.sv
`timescale 1ns/1ps
package dskc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FILL, ST_EMPTY, ST_SECT, ST_TRK, ST_ENG, ST_LOCAL
   } dskc_state_e;

   localparam logic [2:0] FN_FILL  = 3'd0;
   localparam logic [2:0] FN_EMPTY = 3'd1;
   localparam logic [2:0] FN_WRSEC = 3'd2;
   localparam logic [2:0] FN_RDSEC = 3'd3;
   localparam logic [2:0] FN_STAT  = 3'd5;
   localparam logic [2:0] FN_WRDEL = 3'd6;
   localparam logic [2:0] FN_ECODE = 3'd7;

   localparam int B_GO   = 0;
   localparam int B_FN   = 1;
   localparam int B_DRV  = 4;
   localparam int B_DONE = 5;
   localparam int B_IE   = 6;
   localparam int B_TR   = 7;
   localparam int B_INIT = 14;
   localparam int B_ERR  = 15;
endpackage

// File: rtl/dskc_tmr.sv
`timescale 1ns/1ps
module dskc_tmr #(
   parameter int unsigned DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   output logic fire
);
   generate
      if (DLY < 1) begin : g_bad
         $error("dskc_tmr: DLY must be at least 1");
      end
      if (DLY == 1) begin : g_one
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) busy_q <= 1'b0;
            else if (start)    busy_q <= 1'b1;
            else               busy_q <= 1'b0;
         end
         assign fire = busy_q;
      end else begin : g_cnt
         localparam int CW = $clog2(DLY + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)       cnt_q <= '0;
            else if (start)          cnt_q <= CW'(DLY);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign fire = (cnt_q == CW'(1));
      end
   endgenerate
endmodule

// File: rtl/dskc_sbuf.sv
`timescale 1ns/1ps
module dskc_sbuf #(
   parameter int DEPTH = 128,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [W-1:0]  wdata_a,
   output logic [W-1:0]  rdata_a,
   input  logic          we_b,
   input  logic [AW-1:0] addr_b,
   input  logic [W-1:0]  wdata_b,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] mem [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (we_a && addr_a == AW'(i))      mem[i] <= wdata_a;
            else if (we_b && addr_b == AW'(i)) mem[i] <= wdata_b;
         end
      end
   endgenerate

   assign rdata_a = mem[addr_a];
   assign rdata_b = mem[addr_b];
endmodule

// File: rtl/dskc_seq.sv
`timescale 1ns/1ps
module dskc_seq
   import dskc_pkg::*;
#(
   parameter int NBYTES   = 128,
   parameter int XFER_DLY = 2,
   parameter int SECT_W   = 7,
   parameter int TRK_W    = 8,
   localparam int AW      = $clog2(NBYTES),
   localparam int PW      = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic              bus_byte,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              irq,
   output logic              eng_start,
   output logic              eng_pwrup,
   output logic [2:0]        eng_func,
   output logic              eng_drive,
   output logic [SECT_W-1:0] eng_sector,
   output logic [TRK_W-1:0]  eng_track,
   input  logic              eng_done,
   input  logic [7:0]        eng_ecode,
   input  logic [7:0]        eng_status,
   input  logic [AW-1:0]     eng_buf_addr,
   input  logic              eng_buf_we,
   input  logic [7:0]        eng_buf_wdata,
   output logic [7:0]        eng_buf_rdata
);
   localparam logic [PW-1:0] PTR_END  = PW'(NBYTES);
   localparam logic [PW-1:0] PTR_LAST = PW'(NBYTES - 1);

   generate
      if (NBYTES < 2 || (1 << AW) != NBYTES) begin : g_bad_n
         $error("dskc_seq: NBYTES must be a power of two");
      end
      if (SECT_W < 1 || SECT_W > 8 || TRK_W < 1 || TRK_W > 8) begin : g_bad_w
         $error("dskc_seq: sector and track widths must be 1..8");
      end
   endgenerate

   dskc_state_e       st_q;
   logic [7:0]        data_q, esr_q, ecode_q;
   logic [SECT_W-1:0] sect_q;
   logic [TRK_W-1:0]  trk_q;
   logic              err_q, tr_q, ie_q, done_q, drv_q, irq_q;
   logic [2:0]        func_q;
   logic [PW-1:0]     ptr_q;
   logic              start_q, pwrup_q;

   // ---------------- host access decode ----------------
   logic [15:0] csr_view, csr_new;
   logic        acc_csr_wr, acc_db_wr, acc_db_rd;
   logic        do_init, do_go, do_ie, db_take, host_xfer;
   logic        csr_unused;

   assign csr_view = {err_q, 7'b0, tr_q, ie_q, done_q, drv_q, func_q, 1'b0};
   assign csr_new  = !bus_byte   ? bus_wdata :
                     bus_addr[0] ? {bus_wdata[7:0], csr_view[7:0]} :
                                   {csr_view[15:8], bus_wdata[7:0]};
   assign csr_unused = ^{csr_new[15], csr_new[13:7], csr_new[5]};

   assign acc_csr_wr = bus_sel && bus_wr && !bus_addr[1];
   assign acc_db_wr  = bus_sel && bus_wr && bus_addr[1] && !(bus_byte && bus_addr[0]);
   assign acc_db_rd  = bus_sel && !bus_wr && bus_addr[1];

   assign do_init = acc_csr_wr && csr_new[B_INIT];
   assign do_go   = acc_csr_wr && !csr_new[B_INIT] && csr_new[B_GO] && (st_q == ST_IDLE);
   assign do_ie   = acc_csr_wr && !csr_new[B_INIT] && !do_go;
   assign db_take = acc_db_wr && ((st_q == ST_IDLE) || tr_q);

   assign host_xfer = (db_take && (st_q == ST_FILL || st_q == ST_SECT || st_q == ST_TRK))
                    || (acc_db_rd && st_q == ST_EMPTY && tr_q);

   logic [2:0] go_fn;
   logic       go_needs_tmr;
   assign go_fn        = csr_new[B_FN +: 3];
   assign go_needs_tmr = !(go_fn == FN_FILL || go_fn == FN_WRSEC ||
                           go_fn == FN_RDSEC || go_fn == FN_WRDEL);

   // ---------------- pacing timer ----------------
   logic fire;
   dskc_tmr #(.DLY(XFER_DLY)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_init),
      .start (host_xfer || (do_go && go_needs_tmr)),
      .fire  (fire)
   );

   // ---------------- sector buffer ----------------
   logic [7:0] buf_rd;
   dskc_sbuf #(.DEPTH(NBYTES), .W(8)) u_sbuf (
      .clk     (clk),
      .we_a    (fire && st_q == ST_FILL),
      .addr_a  (ptr_q[AW-1:0]),
      .wdata_a (data_q),
      .rdata_a (buf_rd),
      .we_b    (eng_buf_we),
      .addr_b  (eng_buf_addr),
      .wdata_b (eng_buf_wdata),
      .rdata_b (eng_buf_rdata)
   );

   // ---------------- completion decode ----------------
   logic       fin, fin_eng;
   logic [7:0] fin_code, fin_stat;
   assign fin_eng  = (st_q == ST_ENG) && eng_done;
   assign fin      = fin_eng ||
                     (fire && ((st_q == ST_FILL  && ptr_q == PTR_LAST) ||
                               (st_q == ST_EMPTY && ptr_q == PTR_END)  ||
                               (st_q == ST_LOCAL)));
   assign fin_code = fin_eng ? eng_ecode  : 8'h00;
   assign fin_stat = fin_eng ? eng_status : esr_q;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n || do_init) begin
         data_q  <= '0;  esr_q  <= '0;  ecode_q <= '0;
         sect_q  <= '0;  trk_q  <= '0;
         err_q   <= 1'b0; tr_q  <= 1'b0; ie_q   <= 1'b0;
         done_q  <= 1'b0; drv_q <= 1'b0; irq_q  <= 1'b0;
         func_q  <= '0;   ptr_q <= '0;
         st_q    <= rst_n ? ST_ENG : ST_IDLE;
         start_q <= rst_n;
         pwrup_q <= rst_n;
      end else begin
         start_q <= 1'b0;
         if (do_go) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            ie_q   <= csr_new[B_IE];
            drv_q  <= csr_new[B_DRV];
            func_q <= go_fn;
            ptr_q  <= '0;
            unique case (go_fn)
               FN_FILL:                    begin st_q <= ST_FILL; tr_q <= 1'b1; end
               FN_EMPTY:                   begin st_q <= ST_EMPTY; tr_q <= 1'b0; end
               FN_WRSEC, FN_RDSEC, FN_WRDEL: begin st_q <= ST_SECT; tr_q <= 1'b1; end
               default:                    begin st_q <= ST_LOCAL; tr_q <= 1'b0; end
            endcase
         end else begin
            if (db_take)   data_q <= bus_wdata[7:0];
            if (host_xfer) tr_q   <= 1'b0;
            if (fin) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
               tr_q   <= 1'b0;
               if (ie_q) irq_q <= 1'b1;
               if (fin_eng) esr_q <= eng_status;
               if (!fin_eng && func_q == FN_ECODE) begin
                  data_q <= ecode_q;
               end else begin
                  ecode_q <= fin_code;
                  if (fin_code != 8'h00) err_q <= 1'b1;
                  data_q  <= fin_stat;
               end
            end else if (fire) begin
               unique case (st_q)
                  ST_FILL: begin
                     ptr_q <= ptr_q + 1'b1;
                     tr_q  <= 1'b1;
                  end
                  ST_EMPTY: begin
                     data_q <= buf_rd;
                     ptr_q  <= ptr_q + 1'b1;
                     tr_q   <= 1'b1;
                  end
                  ST_SECT: begin
                     sect_q <= data_q[SECT_W-1:0];
                     tr_q   <= 1'b1;
                     st_q   <= ST_TRK;
                  end
                  ST_TRK: begin
                     trk_q   <= data_q[TRK_W-1:0];
                     start_q <= 1'b1;
                     pwrup_q <= 1'b0;
                     st_q    <= ST_ENG;
                  end
                  default: ;
               endcase
            end
            if (do_ie) begin
               ie_q  <= csr_new[B_IE];
               irq_q <= csr_new[B_IE] && (done_q || fin);
            end
         end
      end
   end

   // ---------------- outputs ----------------
   assign bus_rdata  = bus_addr[1] ? {8'h00, data_q}
                                   : {err_q, 7'b0, tr_q, ie_q, done_q, 5'b0};
   assign irq        = irq_q;
   assign eng_start  = start_q;
   assign eng_pwrup  = pwrup_q;
   assign eng_func   = func_q;
   assign eng_drive  = drv_q;
   assign eng_sector = sect_q;
   assign eng_track  = trk_q;
endmodule

// File: rtl/dskc_seq_chk.sv
`timescale 1ns/1ps
module dskc_seq_chk
   import dskc_pkg::*;
#(
   parameter int NBYTES = 128,
   localparam int PW    = $clog2(NBYTES) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input dskc_state_e   st_q,
   input logic          tr_q,
   input logic          done_q,
   input logic          ie_q,
   input logic          irq,
   input logic [7:0]    data_q,
   input logic [2:0]    func_q,
   input logic [PW-1:0] ptr_q,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic          bus_byte,
   input logic [15:0]   bus_wdata,
   input logic          eng_start
);
   logic go_bit, init_bit, csr_wr, odd_db_wr;
   assign csr_wr    = bus_sel && bus_wr && !bus_addr[1];
   assign odd_db_wr = bus_sel && bus_wr && bus_addr == 2'b11 && bus_byte;
   assign go_bit    = bus_byte ? (!bus_addr[0] && bus_wdata[0]) : bus_wdata[0];
   assign init_bit  = bus_byte ? (bus_addr[0] && bus_wdata[6]) : bus_wdata[14];

   // R3
   tr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tr_q |-> st_q != ST_IDLE);

   // R4
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PW'(NBYTES));

   // R5
   odd_lane_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (odd_db_wr && st_q == ST_IDLE) |=> $stable(data_q));

   // R6
   go_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && go_bit && !init_bit && st_q != ST_IDLE) |=> $stable(func_q));

   // R7
   irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> !irq);

   // R8
   irq_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ie_q) |-> irq);

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
endmodule

bind dskc_seq dskc_seq_chk #(.NBYTES(NBYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_q      (st_q),
   .tr_q      (tr_q),
   .done_q    (done_q),
   .ie_q      (ie_q),
   .irq       (irq),
   .data_q    (data_q),
   .func_q    (func_q),
   .ptr_q     (ptr_q),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_byte  (bus_byte),
   .bus_wdata (bus_wdata),
   .eng_start (eng_start)
);

// File: tb/dskc_seq_tb.sv
`timescale 1ns/1ps
module dskc_seq_tb;
   localparam int NB  = 128;
   localparam int DLY = 2;
   localparam int AW  = $clog2(NB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        bus_sel = 0, bus_wr = 0, bus_byte = 0;
   logic [1:0]  bus_addr = 0;
   logic [15:0] bus_wdata = 0, bus_rdata;
   logic        irq, eng_start, eng_pwrup, eng_drive;
   logic [2:0]  eng_func;
   logic [6:0]  eng_sector;
   logic [7:0]  eng_track;
   logic        eng_done = 0;
   logic [7:0]  eng_ecode = 0, eng_status = 0;
   logic [AW-1:0] eng_buf_addr = 0;
   logic        eng_buf_we = 0;
   logic [7:0]  eng_buf_wdata = 0, eng_buf_rdata;

   dskc_seq #(.NBYTES(NB), .XFER_DLY(DLY), .SECT_W(7), .TRK_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
      .eng_pwrup(eng_pwrup), .eng_func(eng_func), .eng_drive(eng_drive),
      .eng_sector(eng_sector), .eng_track(eng_track), .eng_done(eng_done),
      .eng_ecode(eng_ecode), .eng_status(eng_status),
      .eng_buf_addr(eng_buf_addr), .eng_buf_we(eng_buf_we),
      .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata));

   int errors = 0, checks = 0;
   bit finished = 0;

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // engine model
   logic [7:0] nx_ecode = 0, nx_status = 0;
   logic [2:0] cap_func;
   logic       cap_drive, cap_pwrup;
   logic [6:0] cap_sector;
   logic [7:0] cap_track;
   int         starts = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (eng_start) begin
            cap_func = eng_func; cap_drive = eng_drive; cap_pwrup = eng_pwrup;
            cap_sector = eng_sector; cap_track = eng_track;
            starts++;
            repeat (3) @(negedge clk);
            eng_ecode = nx_ecode; eng_status = nx_status; eng_done = 1;
            @(negedge clk);
            eng_done = 0;
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic byt);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_byte = byt;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0; bus_byte = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_byte = 0;
      #1 v = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 0;
   endtask

   task automatic wait_bit(input int b, output int n);
      logic [15:0] v;
      n = 0;
      for (int k = 0; k < 400; k++) begin
         rd(2'b00, v);
         if (v[b]) break;
         n++;
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   // {byte, odd lane, write data, expected readback}
   localparam logic [33:0] VEC [8] = '{
      {1'b0, 1'b0, 16'h0040, 16'h0040},
      {1'b0, 1'b0, 16'h00BE, 16'h0000},
      {1'b0, 1'b0, 16'h80FE, 16'h0040},
      {1'b0, 1'b0, 16'h0000, 16'h0000},
      {1'b1, 1'b0, 16'h0040, 16'h0040},
      {1'b1, 1'b1, 16'h0080, 16'h0040},
      {1'b1, 1'b1, 16'h0000, 16'h0040},
      {1'b1, 1'b0, 16'h00A0, 16'h0000}
   };

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      int n, bad;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      rd(2'b00, v);
      chk(v, 16'h0000, "R1 csr after reset");
      chk({15'b0, irq}, 16'h0, "R1 irq after reset");
      chk({15'b0, eng_start}, 16'h0, "R1 eng_start after reset");

      // R2 R7 R12 table of control writes
      for (int i = 0; i < 8; i++) begin
         wr({1'b0, VEC[i][32]}, VEC[i][31:16], VEC[i][33]);
         rd(2'b00, v);
         chk(v, VEC[i][15:0], $sformatf("R2 R7 R12 vector %0d", i));
      end

      // R3 fill
      wr(2'b00, 16'h0001, 1'b0);
      rd(2'b00, v);
      chk(v, 16'h0080, "R3 fill sets request");
      for (int i = 0; i < NB; i++) begin
         wr(2'b10, {8'h00, pat(i)}, 1'b0);
         if (i == 0) begin
            wait_bit(7, n);
            chk(16'(n), 16'(DLY), "R3 request delay cycles");
         end else if (i == 1) begin
            wr(2'b10, 16'h00EE, 1'b0);   // R5 request clear: ignored
            wait_bit(7, n);
         end else if (i < NB - 1) begin
            wait_bit(7, n);
         end
         if (i == 64) begin
            wr(2'b00, 16'h004B, 1'b0);   // R6 GO while busy
            rd(2'b00, v);
            chk(v, 16'h00C0, "R6 GO while busy only sets enable");
         end
      end
      wait_bit(5, n);
      rd(2'b00, v);
      chk(v, 16'h0060, "R3 R8 fill completes with done");
      chk({15'b0, irq}, 16'h1, "R8 irq on completion");
      rd(2'b10, v);
      chk(v, 16'h0000, "R8 data holds status");
      foreach (VEC[k]) ;
      eng_buf_addr = 0;   #1 chk({8'h0, eng_buf_rdata}, {8'h0, pat(0)},   "R13 R5 buffer byte 0");
      eng_buf_addr = 1;   #1 chk({8'h0, eng_buf_rdata}, {8'h0, pat(1)},   "R13 R5 buffer byte 1");
      eng_buf_addr = 127; #1 chk({8'h0, eng_buf_rdata}, {8'h0, pat(127)}, "R13 R3 buffer byte 127");

      // R7 enable control
      wr(2'b00, 16'h0000, 1'b0);
      chk({15'b0, irq}, 16'h0, "R7 clearing enable drops irq");
      wr(2'b00, 16'h0040, 1'b0);
      chk({15'b0, irq}, 16'h1, "R7 enable while done raises irq");

      // R4 empty
      wr(2'b00, 16'h0003, 1'b0);
      bad = 0;
      for (int i = 0; i < NB; i++) begin
         wait_bit(7, n);
         rd(2'b10, v);
         if (v !== {8'h00, pat(i)}) bad++;
      end
      chk(16'(bad), 16'h0, "R4 empty byte order");
      wait_bit(5, n);
      rd(2'b00, v);
      chk(v, 16'h0020, "R4 empty completes");

      // R5 odd lane and idle write
      wr(2'b11, 16'h005A, 1'b1);
      rd(2'b10, v);
      chk(v, 16'h0000, "R5 odd lane write ignored");
      wr(2'b10, 16'h1234, 1'b0);
      rd(2'b10, v);
      chk(v, 16'h0034, "R5 idle data write stored");

      // R9 read sector, drive 1
      nx_ecode = 8'h00; nx_status = 8'h80;
      wr(2'b00, 16'h0017, 1'b0);
      rd(2'b00, v);
      chk(v, 16'h0080, "R9 sector request");
      wr(2'b10, 16'h0085, 1'b0);
      wait_bit(7, n);
      wr(2'b10, 16'h0021, 1'b0);
      wait_bit(5, n);
      chk({13'b0, cap_func}, 16'h3, "R9 engine function");
      chk({15'b0, cap_drive}, 16'h1, "R9 engine drive");
      chk({9'b0, cap_sector}, 16'h05, "R9 engine sector");
      chk({8'b0, cap_track}, 16'h21, "R9 engine track");
      chk({15'b0, cap_pwrup}, 16'h0, "R9 not power-up");
      rd(2'b10, v);
      chk(v, 16'h0080, "R8 engine status in data");
      rd(2'b00, v);
      chk(v, 16'h0020, "R8 no error");

      // R8 write sector with error
      nx_ecode = 8'h40; nx_status = 8'h08;
      wr(2'b00, 16'h0005, 1'b0);
      wr(2'b10, 16'h0001, 1'b0);
      wait_bit(7, n);
      wr(2'b10, 16'h0002, 1'b0);
      wait_bit(5, n);
      rd(2'b00, v);
      chk(v, 16'h8020, "R8 error set");
      rd(2'b10, v);
      chk(v, 16'h0008, "R8 error status in data");

      // R10 error code and status functions
      wr(2'b00, 16'h000F, 1'b0);
      wait_bit(5, n);
      rd(2'b00, v);
      chk(v, 16'h0020, "R10 error code function keeps error clear");
      rd(2'b10, v);
      chk(v, 16'h0040, "R10 error code in data");
      wr(2'b00, 16'h000B, 1'b0);
      wait_bit(5, n);
      rd(2'b10, v);
      chk(v, 16'h0008, "R10 status function");

      // R11 R12 init through high byte lane
      nx_ecode = 8'h00; nx_status = 8'h84;
      wr(2'b01, 16'h0040, 1'b1);
      rd(2'b00, v);
      chk(v, 16'h0000, "R11 R12 init clears registers");
      wait_bit(5, n);
      chk({15'b0, cap_pwrup}, 16'h1, "R11 power-up start");
      rd(2'b10, v);
      chk(v, 16'h0084, "R11 power-up status");
      rd(2'b00, v);
      chk(v, 16'h0020, "R11 power-up done");

      finish_run();
   end
endmodule